// File: doc/BRIEF.md
# DMA Channel Interrupt and Priority Register Bank

This block is the software-visible control bank that sits beside a seven-channel DMA engine. It holds two 32-bit words. The first is a channel priority word, with one 4-bit field per channel. The second is an interrupt word, which combines read/write enable bits, per-channel completion flags that software clears by writing a one, and a read-only summary bit. Software reaches both words through a plain write strobe and a combinational read port, selected by a word offset.

Each DMA channel drives a one-cycle completion strobe into the bank. When a channel whose interrupt is enabled completes, its flag is latched. The summary bit is then recomputed as the master enable ANDed with "some enabled channel has its flag set". If a completion leaves the summary bit high, the bank sends a one-cycle request pulse toward the system interrupt controller. Register writes and completions that land in the same clock cycle are merged into one update.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, offset 0x70 reads 0x07654321 and offset 0x74 reads 0x00000000, and irqPulse is low.
- R2: Any offset other than 0x70 and 0x74 reads as 0x00000000.
- R3: A write to offset 0x70 stores all 32 data bits, and a later read returns them unchanged.
- R4: In the word at 0x74, bits 5..0, bit 15, bits 22..16 (enable for channel n at bit 16+n) and bit 23 (master enable) take the written value. Bits 14..6 always read 0.
- R5: Flag bits 30..24 (channel n at bit 24+n) are cleared by writing 1 to them. Writing 0 to a flag bit leaves it unchanged.
- R6: Bit 31 always reads as bit 23 AND (any of bits 22..16 ANDed with the matching bit of 30..24). It follows every write, and writing bit 31 directly has no effect.
- R7: A completion strobe on channel n sets flag 24+n only if enable bit 16+n was set in the cycle of the strobe. A strobe on a disabled channel changes nothing.
- R8: irqPulse is high for exactly the one cycle after a clock edge at which a completion set at least one flag and bit 31 became 1.
- R9: Completions on several enabled channels in the same cycle set every matching flag and produce a single one-cycle pulse.
- R10: When a write-one-to-clear and a completion hit the same flag in the same cycle, the flag ends set.
- R11: A completion while the master enable is 0 sets the flag without a pulse. Turning the master enable on later raises bit 31 but produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Byte offset of the addressed word |
| wrEn | input | 1 | Write strobe for the addressed word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr (combinational) |
| xferDone | input | 7 | Per-channel completion strobes, bit n for channel n |
| irqPulse | output | 1 | One-cycle interrupt request toward the interrupt controller |

## Verification
The hardest case to reach from the ports is a single cycle that holds both a write-one-to-clear to the interrupt word and a completion strobe on a channel whose flag is being cleared. The bench produces it by raising wrEn and the xferDone bit at the same falling edge, so both are sampled at one rising edge. It then reads back the flag and watches irqPulse. A second hard case is a pending flag that becomes visible only when the master enable is turned on afterwards. The stimulus builds it by completing a channel with the master enable off, then writing the master enable and checking that bit 31 rises while no pulse appears.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LOW_W    = 6;
  localparam int unsigned FORCE_B  = 15;
  localparam int unsigned ENA_LSB  = 16;
  localparam int unsigned MEN_B    = 23;
  localparam int unsigned FLG_LSB  = 24;
  localparam int unsigned MFLG_B   = 31;

  typedef struct packed {
    logic wrPrio;
    logic wrIrq;
    logic selPrio;
    logic selIrq;
  } regStrobe_t;

endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  PRIO_OFF = 8'h70,
  parameter logic [7:0]  IRQ_OFF  = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              flagRaise,
  input  logic              masterNext,
  output regStrobe_t        strobe,
  output logic              irqPulse
);

  logic hitPrio;
  logic hitIrq;
  logic pulseNext;

  assign hitPrio = (regAddr == ADDR_W'(PRIO_OFF));
  assign hitIrq  = (regAddr == ADDR_W'(IRQ_OFF));

  always_comb begin
    strobe.selPrio = hitPrio;
    strobe.selIrq  = hitIrq;
    strobe.wrPrio  = wrEn && hitPrio;
    strobe.wrIrq   = wrEn && hitIrq;
  end

  // The request fires only when a completion itself raised a flag and the
  // summary bit is high after the merged update.
  assign pulseNext = flagRaise && masterNext;

  always_ff @(posedge clk) begin
    if (!rst_n) irqPulse <= 1'b0;
    else        irqPulse <= pulseNext;
  end

endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int unsigned       NUM_CH     = 7,
  parameter logic [WORD_W-1:0] PRIO_RESET = 32'h0765_4321
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [NUM_CH-1:0] xferDone,
  output logic              flagRaise,
  output logic              masterNext,
  output logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] irqWord
);

  localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'((1 << LOW_W) - 1);
  localparam logic [WORD_W-1:0] ENA_MASK = WORD_W'(((1 << NUM_CH) - 1) << ENA_LSB);
  localparam logic [WORD_W-1:0] RW_MASK  =
    LOW_MASK | ENA_MASK | (WORD_W'(1) << FORCE_B) | (WORD_W'(1) << MEN_B);

  logic [WORD_W-1:0] prioQ;
  logic [WORD_W-1:0] rwQ;
  logic [NUM_CH-1:0] flagQ;
  logic              masterQ;

  logic [WORD_W-1:0] rwNext;
  logic [NUM_CH-1:0] enaCur;
  logic [NUM_CH-1:0] enaNext;
  logic [NUM_CH-1:0] flagNext;
  logic [NUM_CH-1:0] setVec;

  assign enaCur  = rwQ[ENA_LSB +: NUM_CH];
  assign enaNext = rwNext[ENA_LSB +: NUM_CH];
  assign setVec  = xferDone & enaCur;

  always_comb begin
    rwNext = rwQ;
    if (strobe.wrIrq) rwNext = (rwQ & ~RW_MASK) | (wrData & RW_MASK);
  end

  // Per-channel flag: clear-on-one from a write, then completion set wins.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
    logic clrHit;
    assign clrHit       = strobe.wrIrq && wrData[FLG_LSB + ch];
    assign flagNext[ch] = (flagQ[ch] && !clrHit) || setVec[ch];
  end

  assign flagRaise  = |setVec;
  assign masterNext = rwNext[MEN_B] && (|(enaNext & flagNext));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prioQ   <= PRIO_RESET;
      rwQ     <= '0;
      flagQ   <= '0;
      masterQ <= 1'b0;
    end else begin
      if (strobe.wrPrio) prioQ <= wrData;
      rwQ     <= rwNext;
      flagQ   <= flagNext;
      masterQ <= masterNext;
    end
  end

  always_comb begin
    irqWord = rwQ & RW_MASK;
    irqWord[FLG_LSB +: NUM_CH] = flagQ;
    irqWord[MFLG_B] = masterQ;
  end

  always_comb begin
    rdData = '0;
    if (strobe.selPrio)     rdData = prioQ;
    else if (strobe.selIrq) rdData = irqWord;
  end

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CH   = 7,
  parameter logic [7:0]  PRIO_OFF = 8'h70,
  parameter logic [7:0]  IRQ_OFF  = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [NUM_CH-1:0] xferDone,
  output logic              irqPulse
);

  regStrobe_t        strobe;
  logic              flagRaise;
  logic              masterNext;
  logic [WORD_W-1:0] irqWord;

  dma_irq_ctrl #(
    .ADDR_W  (ADDR_W),
    .PRIO_OFF(PRIO_OFF),
    .IRQ_OFF (IRQ_OFF)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .regAddr   (regAddr),
    .wrEn      (wrEn),
    .flagRaise (flagRaise),
    .masterNext(masterNext),
    .strobe    (strobe),
    .irqPulse  (irqPulse)
  );

  dma_irq_datapath #(
    .NUM_CH(NUM_CH)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrData    (wrData),
    .xferDone  (xferDone),
    .flagRaise (flagRaise),
    .masterNext(masterNext),
    .rdData    (rdData),
    .irqWord   (irqWord)
  );

endmodule

// File: rtl/dma_irq_checker.sv
module dma_irq_checker #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CH   = 7,
  parameter logic [7:0]  PRIO_OFF = 8'h70,
  parameter logic [7:0]  IRQ_OFF  = 8'h74
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       rdData,
  input logic [NUM_CH-1:0] xferDone,
  input logic              irqPulse,
  input logic [31:0]       irqWord
);

  // R2: unmapped offsets read zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr != ADDR_W'(PRIO_OFF) && regAddr != ADDR_W'(IRQ_OFF)) |-> rdData == 32'h0);

  // R4: reserved gap in the interrupt word stays zero
  p_gap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irqWord[14:6] == 9'h0);

  // R6: stored summary bit agrees with stored enables and flags
  p_master_consistent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irqWord[31] == (irqWord[23] && (|(irqWord[16 +: NUM_CH] & irqWord[24 +: NUM_CH]))));

  // R8: a pulse follows a completion cycle and coincides with a high summary bit
  p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqPulse |-> ($past(|xferDone) && irqWord[31]));

  // R7 / R10: an enabled completion always leaves its flag set
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xferDone[ch] && irqWord[16 + ch]) |=> irqWord[24 + ch]);
  end

endmodule

bind dma_irq_regs dma_irq_checker #(
  .ADDR_W  (ADDR_W),
  .NUM_CH  (NUM_CH),
  .PRIO_OFF(PRIO_OFF),
  .IRQ_OFF (IRQ_OFF)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .regAddr (regAddr),
  .rdData  (rdData),
  .xferDone(xferDone),
  .irqPulse(irqPulse),
  .irqWord (irqWord)
);

// File: tb/sim_dma_irq_regs.sv
`timescale 1ns/1ps
module sim_dma_irq_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic [6:0]  xferDone = 7'h0;
  logic        irqPulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_irq_regs u0 (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .xferDone(xferDone), .irqPulse(irqPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // completion strobe; returns irqPulse in the cycle after the edge
  task automatic done_ev(input logic [6:0] m, output logic p);
    @(negedge clk);
    xferDone = m;
    @(negedge clk);
    xferDone = 7'h0;
    p = irqPulse;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h70, v); chk("R1 prio reset", v, 32'h0765_4321);
    rd(8'h74, v); chk("R1 irq reset", v, 32'h0);
    chk("R1 pulse reset", {31'h0, irqPulse}, 32'h0);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    rd(8'h00, v); chk("R2 offset 00", v, 32'h0);
    rd(8'h78, v); chk("R2 offset 78", v, 32'h0);
    rd(8'h6C, v); chk("R2 offset 6C", v, 32'h0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr(8'h70, 32'hDEAD_BEEF);
    rd(8'h70, v); chk("R3 prio full word", v, 32'hDEAD_BEEF);
    rd(8'h74, v); chk("R3 irq untouched", v, 32'h0);
  endtask

  task automatic t_rw_bits();
    logic [31:0] v;
    wr(8'h74, 32'hFFFF_FFFF);
    rd(8'h74, v); chk("R4 rw bits set", v, 32'h00FF_803F);
    wr(8'h74, 32'h0000_0000);
    rd(8'h74, v); chk("R4 rw bits clear", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v; logic p;
    wr(8'h74, 32'h0084_0000);
    done_ev(7'h04, p);
    chk("R8 pulse ch2", {31'h0, p}, 32'h1);
    rd(8'h74, v); chk("R7 flag ch2", v, 32'h8484_0000);
    wr(8'h74, 32'h0084_0000);
    rd(8'h74, v); chk("R5 write zero keeps flag", v, 32'h8484_0000);
    wr(8'h74, 32'h0484_0000);
    rd(8'h74, v); chk("R5 write one clears", v, 32'h0084_0000);
  endtask

  task automatic t_late_master();
    logic [31:0] v; logic p;
    wr(8'h74, 32'h0001_0000);
    done_ev(7'h01, p);
    chk("R11 no pulse master off", {31'h0, p}, 32'h0);
    rd(8'h74, v); chk("R11 flag without master", v, 32'h0101_0000);
    @(negedge clk);
    regAddr = 8'h74; wrData = 32'h8081_0000; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R11 no pulse on enable", {31'h0, irqPulse}, 32'h0);
    rd(8'h74, v); chk("R6 master follows write", v, 32'h8181_0000);
    wr(8'h74, 32'h0080_0000);
    rd(8'h74, v); chk("R6 master drops with enable", v, 32'h0180_0000);
  endtask

  task automatic t_multi();
    logic [31:0] v; logic p;
    wr(8'h74, 32'h7FFF_0000);
    rd(8'h74, v); chk("R5 clear all", v, 32'h00FF_0000);
    done_ev(7'h45, p);
    chk("R9 single pulse", {31'h0, p}, 32'h1);
    rd(8'h74, v); chk("R9 all flags", v, 32'hC5FF_0000);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'h0, irqPulse}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v; logic p;
    @(negedge clk);
    regAddr = 8'h74; wrData = 32'h7FFF_0000; wrEn = 1'b1; xferDone = 7'h02;
    @(negedge clk);
    wrEn = 1'b0; xferDone = 7'h00;
    p = irqPulse;
    chk("R10 pulse on collide", {31'h0, p}, 32'h1);
    rd(8'h74, v); chk("R10 set beats clear", v, 32'h82FF_0000);
  endtask

  task automatic t_disabled();
    logic [31:0] v; logic p;
    wr(8'h74, 32'h7F80_0000);
    done_ev(7'h7F, p);
    chk("R7 disabled no pulse", {31'h0, p}, 32'h0);
    rd(8'h74, v); chk("R7 disabled no flag", v, 32'h0080_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_prio();
    t_rw_bits();
    t_w1c();
    t_late_master();
    t_multi();
    t_collide();
    t_disabled();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule